// File: doc/BRIEF.md
# Serial-Controlled SAR Conversion Sequencer

This block is the digital half of a 14-bit successive-approximation converter that a host drives over a three-wire synchronous serial link. The link has a serial clock, an active-low select and a data line. The host clocks in one 8-bit control byte. The block decodes the channel, the input pairing and the clock mode from that byte. It moves the input multiplexer at a fixed serial-clock falling edge, then puts the track/hold into hold at another fixed edge. It then runs a bit-by-bit search: it drives a trial code to the converter's capacitive DAC and reads back the answer of an external comparator. At the end it returns the sampler to track and shifts the result back to the host.

All link pins are oversampled by a fast system clock, so the whole block runs in that single clock domain. The conversion can be paced by the system clock through a divider (internal mode), which ends with a strobe. It can also be paced by the host's own serial-clock edges (external mode), where the conversion closes on a fixed falling-edge count. The comparator decision is a plain input. Analog parts, the reference and power-down are not part of the block.

Top module: `sar_adc_seq`

## Requirements
- R1: The control byte is sampled on serial-clock rising edges, MSB first, while `cs_n` is low. Bit 7 is a start flag and must be 1. Bits 6:4 are the channel number. Bit 3 set means differential and clear means single-ended. Bit 0 set means internal clock mode and clear means external clock mode. Bits 2:1 have no effect.
- R2: The multiplexer select (`pos_sel`, `neg_sel`, `neg_com`) moves to the newly addressed channel on the fifth serial-clock falling edge of the frame and not earlier. `th_hold` is still 0 (track) at that time.
- R3: Single-ended: `pos_sel` is the channel, `neg_com` is 1 and `neg_sel` is 0. Differential: `pos_sel` is the channel, `neg_sel` is the channel with its LSB inverted, and `neg_com` is 0.
- R4: On the eighth falling edge of the frame, `th_hold` and `mux_open` both become 1. The three serial-clock periods between edge five and edge eight are the acquisition window.
- R5: A conversion is 15 steps and resolves bits MSB to LSB. `dac_code` shows the kept bits plus the bit under trial, and starts at 0x2000 when hold begins. A trial bit is kept when `cmp_in` is 1 and cleared otherwise. The 15th step only closes the conversion.
- R6: In internal mode one step is taken every `INT_DIV` system clocks. On completion `sstrb` rises in the same cycle that `th_hold` and `mux_open` return to 0. `sstrb` is 0 during the conversion.
- R7: In external mode one step is taken on each serial-clock edge (rising or falling) after the eighth falling edge. `th_hold` returns to 0 on the eighteenth falling edge of the frame and not earlier. `sstrb` stays 0.
- R8: After completion `th_hold` and `mux_open` are 0 and the select still shows the last programmed channel.
- R9: After completion, each following serial-clock falling edge puts the next result bit on `dout`, MSB first, 14 bits. After that `dout` is 0. `dout` is 0 whenever `cs_n` is high.
- R10: `cs_n` high aborts the frame. The block returns to track with `mux_open` 0 and `sstrb` 0, and the edge count restarts. The next frame counts its edges from one.
- R11: A frame whose start flag is 0 leaves the select unchanged and never enters hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| din | input | 1 | Serial control data |
| cmp_in | input | 1 | Comparator decision: 1 when the input is at or above the trial code |
| dout | output | 1 | Serial result data |
| sstrb | output | 1 | Internal-mode completion strobe |
| pos_sel | output | 3 | Channel routed to the positive sampler input |
| neg_sel | output | 3 | Channel routed to the negative input in differential mode |
| neg_com | output | 1 | Negative input tied to the common pin |
| mux_open | output | 1 | Multiplexer disconnected from the sampler |
| th_hold | output | 1 | Track/hold switch in hold |
| dac_code | output | 14 | Trial code for the capacitive DAC |

## Verification
The bench watches the select at the fourth and fifth falling edges. A design that counted edges from the wrong origin, or kept a stale count after an aborted frame, would switch too early and fail that check. In external mode it checks hold at the seventeenth and eighteenth edges. A design that released hold when the search finished would return to track too early. The bench models the comparator against known analog codes (all ones, zero, alternating patterns and one). A wrong keep/clear rule or a step-count slip shows up as a wrong word on `dout`. Frames with a clear start flag, reserved bits set, and `cs_n` raised during hold check that hold never starts in the first case, that nothing changes in the second, and that hold is released in the third.

// File: rtl/sar_adc_seq_pkg.sv
package sar_adc_seq_pkg;

  localparam int CTRL_BITS = 8;
  localparam int SEL_EDGE  = 5;
  localparam int HOLD_EDGE = 8;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_CONV = 2'd1,
    SEQ_TAIL = 2'd2,
    SEQ_OUT  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/sar_link_rx.sv
module sar_link_rx
  import sar_adc_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk,
  input  logic                 cs_n,
  input  logic                 din,
  output logic                 cs_act_o,
  output logic                 rise_o,
  output logic                 fall_o,
  output logic [CNT_W-1:0]     fall_num_o,
  output logic [CTRL_BITS-1:0] ctrl_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam int LAST = SYNC_STAGES - 1;

  // {din, cs_n, sclk} per stage
  logic [SYNC_STAGES-1:0][2:0] stg_q;
  logic                        sclk_d_q;
  logic [CNT_W-1:0]            cnt_q, cnt_n;
  logic [CTRL_BITS-1:0]        sr_q, sr_n;
  logic                        sclk_s, cs_s, din_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) stg_q[i] <= 3'b010;
      sclk_d_q <= 1'b0;
    end else begin
      stg_q[0] <= {din, cs_n, sclk};
      for (int i = 1; i < SYNC_STAGES; i++) stg_q[i] <= stg_q[i-1];
      sclk_d_q <= stg_q[LAST][0];
    end
  end

  assign sclk_s   = stg_q[LAST][0];
  assign cs_s     = stg_q[LAST][1];
  assign din_s    = stg_q[LAST][2];
  assign cs_act_o = ~cs_s;
  assign rise_o   = ~cs_s & sclk_s & ~sclk_d_q;
  assign fall_o   = ~cs_s & ~sclk_s & sclk_d_q;

  always_comb begin
    cnt_n = cnt_q;
    sr_n  = sr_q;
    if (cs_s) begin
      cnt_n = '0;
      sr_n  = '0;
    end else begin
      if (fall_o && cnt_q != CNT_MAX) cnt_n = cnt_q + 1'b1;
      if (rise_o && cnt_q < CNT_W'(CTRL_BITS)) sr_n = {sr_q[CTRL_BITS-2:0], din_s};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sr_q  <= '0;
    end else begin
      cnt_q <= cnt_n;
      sr_q  <= sr_n;
    end
  end

  assign fall_num_o = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
  assign ctrl_o     = sr_q;

endmodule

// File: rtl/sar_step_engine.sv
module sar_step_engine #(
  parameter int RES_BITS = 14,
  parameter int INT_DIV  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                abort_i,
  input  logic                int_mode_i,
  input  logic                ext_step_i,
  input  logic                cmp_i,
  output logic [RES_BITS-1:0] code_o,
  output logic                done_o
);

  localparam int SW = $clog2(RES_BITS + 1);
  localparam logic [RES_BITS-1:0] TOP_BIT = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [RES_BITS-1:0] code_q, code_n, trial_q, trial_n;
  logic [SW-1:0]       cnt_q, cnt_n;
  logic                busy_q, busy_n;
  logic                div_tick, step, last;

  generate
    if (INT_DIV <= 1) begin : g_nodiv
      assign div_tick = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(INT_DIV);
      logic [DW-1:0] div_q, div_n;
      assign div_tick = (div_q == DW'(INT_DIV - 1));
      always_comb begin
        if (start_i || !busy_q || div_tick) div_n = '0;
        else                                div_n = div_q + 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_n;
      end
    end
  endgenerate

  assign step   = busy_q & (int_mode_i ? div_tick : ext_step_i);
  assign last   = (cnt_q == SW'(RES_BITS));
  assign done_o = step & last & ~abort_i & ~start_i;

  always_comb begin
    code_n  = code_q;
    trial_n = trial_q;
    cnt_n   = cnt_q;
    busy_n  = busy_q;
    if (abort_i) begin
      busy_n  = 1'b0;
      trial_n = '0;
    end else if (start_i) begin
      code_n  = '0;
      trial_n = TOP_BIT;
      cnt_n   = '0;
      busy_n  = 1'b1;
    end else if (step) begin
      if (last) begin
        busy_n = 1'b0;
      end else begin
        if (cmp_i) code_n = code_q | trial_q;
        trial_n = trial_q >> 1;
        cnt_n   = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      trial_q <= '0;
      cnt_q   <= '0;
      busy_q  <= 1'b0;
    end else begin
      code_q  <= code_n;
      trial_q <= trial_n;
      cnt_q   <= cnt_n;
      busy_q  <= busy_n;
    end
  end

  assign code_o = code_q | trial_q;

endmodule

// File: rtl/sar_dout_shift.sv
module sar_dout_shift #(
  parameter int RES_BITS = 14
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic                shift_i,
  input  logic [RES_BITS-1:0] data_i,
  output logic                bit_o
);

  logic [RES_BITS-1:0] word_q, word_n;
  logic                bit_q, bit_n;

  always_comb begin
    word_n = word_q;
    bit_n  = bit_q;
    if (load_i) begin
      word_n = data_i;
      bit_n  = 1'b0;
    end else if (shift_i) begin
      bit_n  = word_q[RES_BITS-1];
      word_n = {word_q[RES_BITS-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      bit_q  <= 1'b0;
    end else begin
      word_q <= word_n;
      bit_q  <= bit_n;
    end
  end

  assign bit_o = bit_q;

endmodule

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
  import sar_adc_seq_pkg::*;
#(
  parameter int RES_BITS      = 14,
  parameter int SYNC_STAGES   = 2,
  parameter int INT_DIV       = 2,
  parameter int EXT_DONE_EDGE = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk,
  input  logic                cs_n,
  input  logic                din,
  input  logic                cmp_in,
  output logic                dout,
  output logic                sstrb,
  output logic [2:0]          pos_sel,
  output logic [2:0]          neg_sel,
  output logic                neg_com,
  output logic                mux_open,
  output logic                th_hold,
  output logic [RES_BITS-1:0] dac_code
);

  localparam int CNT_W = $clog2(EXT_DONE_EDGE + 2);

  logic                 cs_act, rise_evt, fall_evt;
  logic [CNT_W-1:0]     fall_num;
  logic [CTRL_BITS-1:0] ctrl;
  logic [RES_BITS-1:0]  code;
  logic                 eng_done, dout_bit;

  seq_state_e state_q, state_n;
  logic [2:0] ch_q, ch_n;
  logic       diff_q, diff_n;
  logic       int_q, int_n;
  logic       strb_q, strb_n;
  logic       sel_go, start_go, tail_end, load_out, shift_out;

  sar_link_rx #(.SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .cs_act_o(cs_act), .rise_o(rise_evt), .fall_o(fall_evt),
    .fall_num_o(fall_num), .ctrl_o(ctrl)
  );

  // edge 5: ctrl[4] start, ctrl[3:1] channel, ctrl[0] pairing
  assign sel_go   = (state_q == SEQ_IDLE) & fall_evt & (fall_num == CNT_W'(SEL_EDGE)) & ctrl[4];
  // edge 8: ctrl[7] start, ctrl[0] clock mode
  assign start_go = (state_q == SEQ_IDLE) & fall_evt & (fall_num == CNT_W'(HOLD_EDGE)) & ctrl[7];
  assign tail_end = (state_q == SEQ_TAIL) & fall_evt & (fall_num == CNT_W'(EXT_DONE_EDGE));

  sar_step_engine #(.RES_BITS(RES_BITS), .INT_DIV(INT_DIV)) u_eng (
    .clk(clk), .rst_n(rst_n), .start_i(start_go), .abort_i(~cs_act),
    .int_mode_i(int_q), .ext_step_i(rise_evt | fall_evt), .cmp_i(cmp_in),
    .code_o(code), .done_o(eng_done)
  );

  assign load_out  = cs_act & (((state_q == SEQ_CONV) & eng_done & int_q) | tail_end);
  assign shift_out = cs_act & (state_q == SEQ_OUT) & fall_evt;

  sar_dout_shift #(.RES_BITS(RES_BITS)) u_out (
    .clk(clk), .rst_n(rst_n), .load_i(load_out), .shift_i(shift_out),
    .data_i(code), .bit_o(dout_bit)
  );

  always_comb begin
    state_n = state_q;
    ch_n    = ch_q;
    diff_n  = diff_q;
    int_n   = int_q;
    strb_n  = strb_q;
    if (sel_go) begin
      ch_n   = ctrl[3:1];
      diff_n = ctrl[0];
    end
    if (!cs_act) begin
      state_n = SEQ_IDLE;
      strb_n  = 1'b0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (start_go) begin
          state_n = SEQ_CONV;
          int_n   = ctrl[0];
          strb_n  = 1'b0;
        end
        SEQ_CONV: if (eng_done) begin
          state_n = int_q ? SEQ_OUT : SEQ_TAIL;
          strb_n  = int_q;
        end
        SEQ_TAIL: if (tail_end) state_n = SEQ_OUT;
        SEQ_OUT:  state_n = SEQ_OUT;
        default:  state_n = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      ch_q    <= '0;
      diff_q  <= 1'b0;
      int_q   <= 1'b0;
      strb_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      ch_q    <= ch_n;
      diff_q  <= diff_n;
      int_q   <= int_n;
      strb_q  <= strb_n;
    end
  end

  assign th_hold  = (state_q == SEQ_CONV) | (state_q == SEQ_TAIL);
  assign mux_open = th_hold;
  assign sstrb    = strb_q;
  assign pos_sel  = ch_q;
  assign neg_sel  = diff_q ? {ch_q[2:1], ~ch_q[0]} : 3'd0;
  assign neg_com  = ~diff_q;
  assign dac_code = code;
  assign dout     = ~cs_n & dout_bit;

endmodule

// File: rtl/sar_adc_seq_chk.sv
module sar_adc_seq_chk #(
  parameter int RES_BITS = 14
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cs_n,
  input logic                th_hold,
  input logic                mux_open,
  input logic                sstrb,
  input logic [2:0]          pos_sel,
  input logic [RES_BITS-1:0] dac_code
);

  localparam logic [RES_BITS-1:0] TOP_BIT = {1'b1, {(RES_BITS-1){1'b0}}};

  // R2
  mux_move_in_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_sel != $past(pos_sel)) |-> !$past(th_hold));

  // R5
  hold_start_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(th_hold) |-> (dac_code == TOP_BIT));

  // R6
  strobe_in_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sstrb) |-> (!th_hold && !mux_open));

  // R6
  strobe_code_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sstrb |-> $stable(dac_code));

  // R10
  abort_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |=> (!th_hold && !sstrb));

endmodule

bind sar_adc_seq sar_adc_seq_chk #(.RES_BITS(RES_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .th_hold(th_hold),
  .mux_open(mux_open), .sstrb(sstrb), .pos_sel(pos_sel), .dac_code(dac_code)
);

// File: tb/sar_adc_seq_tb.sv
module sar_adc_seq_tb;

  localparam int H = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        din = 1'b0;
  logic        cmp_in;
  logic        dout, sstrb, neg_com, mux_open, th_hold;
  logic [2:0]  pos_sel, neg_sel;
  logic [13:0] dac_code;
  logic [13:0] vin = '0;
  logic [2:0]  cur_pos = 3'd0;
  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  // comparator model
  assign cmp_in = (vin >= dac_code);

  sar_adc_seq u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .cmp_in(cmp_in), .dout(dout), .sstrb(sstrb), .pos_sel(pos_sel),
    .neg_sel(neg_sel), .neg_com(neg_com), .mux_open(mux_open),
    .th_hold(th_hold), .dac_code(dac_code)
  );

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulse();
    sclk = 1'b1; wclk(H); sclk = 1'b0; wclk(H);
  endtask

  // sends a control byte; checks the select around the fifth falling edge
  task automatic send_ctrl(input logic [7:0] b, input logic [2:0] new_pos);
    cs_n = 1'b0; wclk(H);
    for (int i = 0; i < 8; i++) begin
      din = b[7-i]; wclk(H);
      sclk = 1'b1; wclk(H);
      if (i == 4) chk("R2", "select before edge 5", 32'(pos_sel), 32'(cur_pos));
      sclk = 1'b0;
      if (i == 4) begin
        wclk(6);
        chk("R2", "select after edge 5", 32'(pos_sel), 32'(new_pos));
        chk("R2", "track at edge 5", 32'(th_hold), 32'd0);
        cur_pos = new_pos;
      end
    end
  endtask

  task automatic read_result(input string req, input logic [13:0] exp);
    logic [13:0] got;
    for (int k = 13; k >= 0; k--) begin
      sclk = 1'b1; wclk(H); sclk = 1'b0; wclk(6);
      got[k] = dout; wclk(H - 6);
    end
    chk(req, "result word on dout", 32'(got), 32'(exp));
    pulse();
    chk("R9", "dout after last bit", 32'(dout), 32'd0);
  endtask

  task automatic end_frame();
    wclk(H); cs_n = 1'b1; wclk(H);
  endtask

  task automatic t_reset();
    chk("R8", "reset pos_sel", 32'(pos_sel), 32'd0);
    chk("R3", "reset neg_com", 32'(neg_com), 32'd1);
    chk("R4", "reset hold/open", 32'({th_hold, mux_open}), 32'd0);
    chk("R6", "reset sstrb", 32'(sstrb), 32'd0);
    chk("R9", "reset dout", 32'(dout), 32'd0);
  endtask

  task automatic t_single_internal();
    vin = 14'h2AAA;
    send_ctrl(8'b1_011_0_001, 3'd3);
    wclk(6);
    chk("R4", "hold/open after edge 8", 32'({th_hold, mux_open}), 32'd3);
    chk("R6", "sstrb low in conversion", 32'(sstrb), 32'd0);
    chk("R3", "single-ended neg_com", 32'(neg_com), 32'd1);
    chk("R3", "single-ended neg_sel", 32'(neg_sel), 32'd0);
    wclk(60);
    chk("R6", "sstrb after internal conversion", 32'(sstrb), 32'd1);
    chk("R8", "track and closed after completion", 32'({th_hold, mux_open}), 32'd0);
    chk("R8", "select kept", 32'(pos_sel), 32'd3);
    chk("R9", "dout before first shift", 32'(dout), 32'd0);
    read_result("R5", 14'h2AAA);
    end_frame();
  endtask

  task automatic t_diff_internal();
    vin = 14'h3FFF;
    // reserved bits 2:1 set: no effect (R1)
    send_ctrl(8'b1_101_1_111, 3'd5);
    wclk(6);
    chk("R3", "differential neg_sel", 32'(neg_sel), 32'd4);
    chk("R3", "differential neg_com", 32'(neg_com), 32'd0);
    wclk(60);
    chk("R1", "internal mode with reserved bits set", 32'(sstrb), 32'd1);
    sclk = 1'b1; wclk(H); sclk = 1'b0; wclk(6);
    chk("R9", "first result bit", 32'(dout), 32'd1);
    cs_n = 1'b1; wclk(2);
    chk("R9", "dout zero while cs_n high", 32'(dout), 32'd0);
    wclk(H);
  endtask

  task automatic t_external();
    vin = 14'h1555;
    send_ctrl(8'b1_110_1_000, 3'd6);
    wclk(6);
    chk("R3", "pair of channel 6", 32'(neg_sel), 32'd7);
    for (int p = 9; p <= 17; p++) pulse();
    chk("R7", "still hold at edge 17", 32'(th_hold), 32'd1);
    sclk = 1'b1; wclk(H); sclk = 1'b0; wclk(6);
    chk("R7", "track at edge 18", 32'({th_hold, mux_open}), 32'd0);
    chk("R7", "sstrb stays low", 32'(sstrb), 32'd0);
    wclk(H - 6);
    read_result("R7", 14'h1555);
    end_frame();
  endtask

  task automatic t_abort();
    cs_n = 1'b0; wclk(H);
    for (int i = 0; i < 3; i++) begin
      din = 1'b1; wclk(H); sclk = 1'b1; wclk(H); sclk = 1'b0;
    end
    end_frame();
    chk("R10", "select unchanged by partial frame", 32'(pos_sel), 32'(cur_pos));
    vin = 14'h0000;
    send_ctrl(8'b1_001_0_001, 3'd1);
    wclk(6);
    chk("R10", "hold before abort", 32'(th_hold), 32'd1);
    cs_n = 1'b1; wclk(6);
    chk("R10", "track after abort", 32'({th_hold, mux_open, sstrb}), 32'd0);
    wclk(H);
    vin = 14'h0001;
    send_ctrl(8'b1_001_0_001, 3'd1);
    wclk(66);
    chk("R10", "frame after abort completes", 32'(sstrb), 32'd1);
    read_result("R10", 14'h0001);
    end_frame();
  endtask

  task automatic t_nostart();
    send_ctrl(8'b0_010_0_001, cur_pos);
    wclk(6);
    chk("R11", "no hold without start flag", 32'(th_hold), 32'd0);
    wclk(60);
    chk("R11", "no strobe without start flag", 32'(sstrb), 32'd0);
    chk("R11", "select unchanged", 32'(pos_sel), 32'(cur_pos));
    end_frame();
  endtask

  initial begin
    wclk(4);
    t_reset();
    rst_n = 1'b1;
    wclk(4);
    t_single_internal();
    t_diff_internal();
    t_external();
    t_abort();
    t_nostart();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1 run did not finish: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule